// File: doc/BRIEF.md
# Paired-Page Cell Level Corrector

This block performs the cell-level step of a joint error-correction scheme for two pages stored in the same row of two-bit-per-cell flash. One page holds the upper bit of every cell, the other the lower bit. The block makes no attempt to find errors. An external long-code decoder finds them in the XOR of the two pages. The block then moves each flagged cell one voltage level back along a fixed state rule. Next, an external short-code decoder runs over the upper page and then over the lower page, and the block applies the bit flips that decoder reports.

On the write side the block supplies the XOR sum page that the long-code encoder needs. It also supplies the lower page's check bits, formed from the two stored parity fields. These two outputs are combinational from the inputs.

A six-state sequencer drives the read side in this order: IDLE, SUM, ADJUST, MSB_CHK, LSB_CHK, DONE.
- IDLE goes to SUM when `start` is high. The inputs are captured on that edge.
- SUM goes to ADJUST on `dec_done`. The returned mask is kept as the error-location mask.
- ADJUST goes to MSB_CHK after exactly one cycle. The level shift is applied on that edge.
- MSB_CHK goes to LSB_CHK on `dec_done`. The mask is XORed into the upper page.
- LSB_CHK goes to DONE on `dec_done`. The mask is XORed into the lower page.
- DONE goes back to IDLE after one cycle.

Cell states are written upper/lower. From the lowest voltage level up, the four states are 11, 10, 00, 01.

Top module: `mlc_pair_adjuster`

## Requirements
- R1: After reset, `busy`, `done` and `dec_req` are 0, and `msb_out` and `lsb_out` are all zeros.
- R2: `sum_page` always equals `msb_in` XOR `lsb_in`, in the same cycle.
- R3: `lsb_chk` always equals `short_par_in` XOR the low CELL_R1 bits of `long_par_in` (bit i with bit i, for i below CELL_R1).
- R4: When `start` is high in IDLE, the inputs are captured. In the next cycle, `dec_req` is 1 and `dec_step` is 0 (long code). At the same time, `dec_word` is the captured upper page XOR the captured lower page, and `dec_par` is the captured long parity.
- R5: In ADJUST, each cell whose bit is set in the mask returned at the end of SUM changes state as follows: 11 becomes 10, 10 becomes 11, 00 becomes 10, and 01 becomes 00.
- R6: A cell whose mask bit is 0 keeps both of its bits through ADJUST.
- R7: In MSB_CHK, `dec_step` is 1 and `dec_word` is the adjusted upper page. `dec_par` is the short parity, zero-extended. On `dec_done`, `dec_mask` is XORed into the upper page.
- R8: In LSB_CHK, `dec_step` is 2 and `dec_word` is the adjusted lower page. `dec_par` is the zero-extended XOR of the short parity with the low CELL_R1 bits of the long parity. On `dec_done`, `dec_mask` is XORed into the lower page.
- R9: The steps run in the order long code, ADJUST, upper page, lower page. ADJUST lasts exactly one cycle, with `dec_req` low.
- R10: `done` is a one-cycle pulse in the cycle after the lower-page `dec_done`. From then until the next start, `msb_out` and `lsb_out` hold the corrected pages.
- R11: `start` has no effect while `busy` is 1, and `dec_done` has no effect while `dec_req` is 0.
- R12: While `dec_req` is 1 and `dec_done` is 0, `dec_req` stays 1 and `dec_step` and `dec_word` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction pass (taken in IDLE only) |
| msb_in | input | CELLS | Upper-bit page as read |
| lsb_in | input | CELLS | Lower-bit page as read |
| short_par_in | input | CELL_R1 | Stored short-code parity of the upper page |
| long_par_in | input | CELL_R2 | Stored long-code parity of the sum page |
| sum_page | output | CELLS | XOR of the two input pages, for encoding |
| lsb_chk | output | CELL_R1 | Derived check bits for the lower page |
| busy | output | 1 | Sequencer not in IDLE |
| done | output | 1 | One-cycle completion pulse |
| dec_req | output | 1 | Request to the external decoder, held until `dec_done` |
| dec_step | output | 2 | 0 long code on sum, 1 short code on upper, 2 short code on lower |
| dec_word | output | CELLS | Word the decoder works on |
| dec_par | output | CELL_R2 | Parity field for the decoder (short fields zero-extended) |
| dec_done | input | 1 | Decoder finished the current step |
| dec_mask | input | CELLS | Error locations returned with `dec_done` |
| msb_out | output | CELLS | Corrected upper page |
| lsb_out | output | CELLS | Corrected lower page |

## Verification
The combinational encode path (R2, R3) and the sequenced correction path can be active in the same cycle. The bench changes `msb_in` and pulses `start` again while the SUM step is outstanding. It then checks two things: `sum_page` follows the new inputs at once, and the decoder word and the final pages still come from the captured pages. A stray `dec_done`, carrying a mask, is also driven in IDLE in the cycle of `start`. This shows that a finish from the decoder while no request is open does not disturb the pass. All combinations of the two pages and the error mask are swept in a four-cell configuration.

// File: rtl/mlc_adj_pkg.sv
package mlc_adj_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SUM,
        S_ADJUST,
        S_MSB_CHK,
        S_LSB_CHK,
        S_DONE
    } adj_state_e;

    localparam logic [1:0] STEP_LONG = 2'd0;
    localparam logic [1:0] STEP_MSB  = 2'd1;
    localparam logic [1:0] STEP_LSB  = 2'd2;
endpackage

// File: rtl/mlc_cell_shift.sv
module mlc_cell_shift #(
    parameter int CELLS = 16
) (
    input  logic [CELLS-1:0] up_i,
    input  logic [CELLS-1:0] lo_i,
    input  logic [CELLS-1:0] flag_i,
    output logic [CELLS-1:0] up_o,
    output logic [CELLS-1:0] lo_o
);
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        always_comb begin
            up_o[c] = up_i[c];
            lo_o[c] = lo_i[c];
            if (flag_i[c]) begin
                unique case ({up_i[c], lo_i[c]})
                    2'b11:   {up_o[c], lo_o[c]} = 2'b10;
                    2'b10:   {up_o[c], lo_o[c]} = 2'b11;
                    2'b00:   {up_o[c], lo_o[c]} = 2'b10;
                    default: {up_o[c], lo_o[c]} = 2'b00;
                endcase
            end
        end
    end
endmodule

// File: rtl/mlc_pair_encode.sv
module mlc_pair_encode #(
    parameter int CELLS   = 16,
    parameter int CELL_R1 = 4,
    parameter int CELL_R2 = 8
) (
    input  logic [CELLS-1:0]   up_i,
    input  logic [CELLS-1:0]   lo_i,
    input  logic [CELL_R1-1:0] short_i,
    input  logic [CELL_R2-1:0] long_i,
    output logic [CELLS-1:0]   sum_o,
    output logic [CELL_R1-1:0] chk_o
);
    always_comb begin
        sum_o = up_i ^ lo_i;
        chk_o = short_i ^ long_i[CELL_R1-1:0];
    end
endmodule

// File: rtl/mlc_adj_seq.sv
module mlc_adj_seq
    import mlc_adj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dec_done,
    output logic       busy,
    output logic       done,
    output logic       dec_req,
    output logic [1:0] dec_step,
    output logic       ld_in,
    output logic       ld_err,
    output logic       ld_adj,
    output logic       ld_msb,
    output logic       ld_lsb
);
    adj_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)    state_d = S_SUM;
            S_SUM:     if (dec_done) state_d = S_ADJUST;
            S_ADJUST:                state_d = S_MSB_CHK;
            S_MSB_CHK: if (dec_done) state_d = S_LSB_CHK;
            S_LSB_CHK: if (dec_done) state_d = S_DONE;
            S_DONE:                  state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        dec_req  = 1'b0;
        dec_step = STEP_LONG;
        ld_in    = 1'b0;
        ld_err   = 1'b0;
        ld_adj   = 1'b0;
        ld_msb   = 1'b0;
        ld_lsb   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy  = 1'b0;
                ld_in = start;
            end
            S_SUM: begin
                dec_req = 1'b1;
                ld_err  = dec_done;
            end
            S_ADJUST: ld_adj = 1'b1;
            S_MSB_CHK: begin
                dec_req  = 1'b1;
                dec_step = STEP_MSB;
                ld_msb   = dec_done;
            end
            S_LSB_CHK: begin
                dec_req  = 1'b1;
                dec_step = STEP_LSB;
                ld_lsb   = dec_done;
            end
            S_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/mlc_pair_adjuster.sv
module mlc_pair_adjuster
    import mlc_adj_pkg::*;
#(
    parameter int CELLS   = 16,
    parameter int CELL_R1 = 4,
    parameter int CELL_R2 = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CELLS-1:0]   msb_in,
    input  logic [CELLS-1:0]   lsb_in,
    input  logic [CELL_R1-1:0] short_par_in,
    input  logic [CELL_R2-1:0] long_par_in,
    output logic [CELLS-1:0]   sum_page,
    output logic [CELL_R1-1:0] lsb_chk,
    output logic               busy,
    output logic               done,
    output logic               dec_req,
    output logic [1:0]         dec_step,
    output logic [CELLS-1:0]   dec_word,
    output logic [CELL_R2-1:0] dec_par,
    input  logic               dec_done,
    input  logic [CELLS-1:0]   dec_mask,
    output logic [CELLS-1:0]   msb_out,
    output logic [CELLS-1:0]   lsb_out
);
    localparam int PAD = CELL_R2 - CELL_R1;

    logic [CELLS-1:0]   up_q, lo_q, err_q, up_adj, lo_adj, sum_q;
    logic [CELL_R1-1:0] sp_q, chk_q;
    logic [CELL_R2-1:0] lp_q;
    logic ld_in, ld_err, ld_adj, ld_msb, ld_lsb;

    mlc_adj_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dec_done(dec_done),
        .busy(busy), .done(done), .dec_req(dec_req), .dec_step(dec_step),
        .ld_in(ld_in), .ld_err(ld_err), .ld_adj(ld_adj),
        .ld_msb(ld_msb), .ld_lsb(ld_lsb)
    );

    // Write-side encoding from the live inputs
    mlc_pair_encode #(.CELLS(CELLS), .CELL_R1(CELL_R1), .CELL_R2(CELL_R2)) u_enc_in (
        .up_i(msb_in), .lo_i(lsb_in), .short_i(short_par_in), .long_i(long_par_in),
        .sum_o(sum_page), .chk_o(lsb_chk)
    );

    // Same combination over the captured pages, feeding the decoders
    mlc_pair_encode #(.CELLS(CELLS), .CELL_R1(CELL_R1), .CELL_R2(CELL_R2)) u_enc_q (
        .up_i(up_q), .lo_i(lo_q), .short_i(sp_q), .long_i(lp_q),
        .sum_o(sum_q), .chk_o(chk_q)
    );

    mlc_cell_shift #(.CELLS(CELLS)) u_shift (
        .up_i(up_q), .lo_i(lo_q), .flag_i(err_q),
        .up_o(up_adj), .lo_o(lo_adj)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q  <= '0;
            lo_q  <= '0;
            err_q <= '0;
            sp_q  <= '0;
            lp_q  <= '0;
        end else begin
            if (ld_in) begin
                up_q <= msb_in;
                lo_q <= lsb_in;
                sp_q <= short_par_in;
                lp_q <= long_par_in;
            end
            if (ld_err) err_q <= dec_mask;
            if (ld_adj) begin
                up_q <= up_adj;
                lo_q <= lo_adj;
            end
            if (ld_msb) up_q <= up_q ^ dec_mask;
            if (ld_lsb) lo_q <= lo_q ^ dec_mask;
        end
    end

    always_comb begin
        unique case (dec_step)
            STEP_MSB: begin
                dec_word = up_q;
                dec_par  = {{PAD{1'b0}}, sp_q};
            end
            STEP_LSB: begin
                dec_word = lo_q;
                dec_par  = {{PAD{1'b0}}, chk_q};
            end
            default: begin
                dec_word = sum_q;
                dec_par  = lp_q;
            end
        endcase
    end

    assign msb_out = up_q;
    assign lsb_out = lo_q;
endmodule

// File: rtl/mlc_pair_adjuster_chk.sv
module mlc_pair_adjuster_chk #(
    parameter int CELLS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             dec_req,
    input logic [1:0]       dec_step,
    input logic             dec_done,
    input logic [CELLS-1:0] dec_word,
    input logic [CELLS-1:0] msb_out,
    input logic [CELLS-1:0] lsb_out
);
    // R4
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (dec_req && dec_step == 2'd0));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && !dec_done) |=> (dec_req && $stable(dec_step) && $stable(dec_word)));

    // R9
    adjust_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && dec_done && dec_step == 2'd0) |=> (!dec_req && busy));

    // R9
    upper_to_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && dec_done && dec_step == 2'd1) |=> (dec_req && dec_step == 2'd2));

    // R10
    done_after_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && dec_done && dec_step == 2'd2) |=> done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(msb_out) && $stable(lsb_out)));
endmodule

bind mlc_pair_adjuster mlc_pair_adjuster_chk #(.CELLS(CELLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .dec_req(dec_req), .dec_step(dec_step), .dec_done(dec_done),
    .dec_word(dec_word), .msb_out(msb_out), .lsb_out(lsb_out)
);

// File: tb/test_mlc_pair_adjuster.sv
`timescale 1ns/1ps
module test_mlc_pair_adjuster;
    localparam int N  = 4;
    localparam int Q1 = 2;
    localparam int Q2 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] msb_in = '0, lsb_in = '0, dec_mask = '0;
    logic [Q1-1:0] short_par_in = '0;
    logic [Q2-1:0] long_par_in = '0;
    logic dec_done = 1'b0;
    logic [N-1:0] sum_page, dec_word, msb_out, lsb_out;
    logic [Q1-1:0] lsb_chk;
    logic [Q2-1:0] dec_par;
    logic busy, done, dec_req;
    logic [1:0] dec_step;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mlc_pair_adjuster #(.CELLS(N), .CELL_R1(Q1), .CELL_R2(Q2)) i_mlc_pair_adjuster (
        .clk(clk), .rst_n(rst_n), .start(start), .msb_in(msb_in), .lsb_in(lsb_in),
        .short_par_in(short_par_in), .long_par_in(long_par_in),
        .sum_page(sum_page), .lsb_chk(lsb_chk), .busy(busy), .done(done),
        .dec_req(dec_req), .dec_step(dec_step), .dec_word(dec_word), .dec_par(dec_par),
        .dec_done(dec_done), .dec_mask(dec_mask), .msb_out(msb_out), .lsb_out(lsb_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // level index from lowest voltage: 11,10,00,01
    function automatic int lvl_of(input bit u, input bit l);
        int r;
        if (u && l)       r = 0;
        else if (u && !l) r = 1;
        else if (!u && !l) r = 2;
        else              r = 3;
        return r;
    endfunction

    task automatic expect_adj(input int m, input int l, input int e,
                              output int am, output int al);
        am = 0;
        al = 0;
        for (int c = 0; c < N; c++) begin
            int v;
            bit u, w;
            v = lvl_of(m[c], l[c]);
            if (e[c]) v = (v == 0) ? 1 : v - 1;
            u = (v <= 1);
            w = (v == 0) || (v == 3);
            am = am | (int'(u) << c);
            al = al | (int'(w) << c);
        end
    endtask

    task automatic run_one(input int m, input int l, input int e, input int dly);
        int s1, s2, mm, lm, am, al, chk;
        s1 = (m ^ e) & 3;
        s2 = (l * 5 + e) & 7;
        mm = ((e >> 1) | (e << 3)) & 15;
        lm = m ^ l;
        chk = s1 ^ (s2 & 3);
        expect_adj(m, l, e, am, al);

        @(negedge clk);
        msb_in = m[N-1:0];
        lsb_in = l[N-1:0];
        short_par_in = s1[Q1-1:0];
        long_par_in = s2[Q2-1:0];
        start = 1'b1;
        dec_done = 1'b1;            // R11 stray finish while no request is open
        dec_mask = ~e[N-1:0];
        #1;
        check("R2 sum_page", int'(sum_page), m ^ l);
        check("R3 lsb_chk", int'(lsb_chk), chk);

        @(negedge clk);
        dec_done = 1'b0;
        msb_in = ~m[N-1:0];         // R11 restart attempt while busy
        #1;
        check("R2 sum_page follows live input", int'(sum_page), (~m ^ l) & 15);
        check("R4 long step", {int'(dec_req), int'(dec_step)}, {1, 0});
        check("R4 long word", int'(dec_word), m ^ l);
        check("R4 long parity", int'(dec_par), s2);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            start = 1'b0;
            #1;
            check("R12 request held", {int'(dec_req), int'(dec_step), int'(dec_word)},
                  {1, 0, m ^ l});
        end
        start = 1'b0;
        dec_done = 1'b1;
        dec_mask = e[N-1:0];

        @(negedge clk);
        dec_done = 1'b0;
        #1;
        check("R9 adjust gap", int'(dec_req), 0);

        @(negedge clk);
        #1;
        check("R7 upper step", int'(dec_step), 1);
        check("R5 R6 upper adjusted", int'(dec_word), am);
        check("R7 upper parity", int'(dec_par), s1);
        dec_done = 1'b1;
        dec_mask = mm[N-1:0];

        @(negedge clk);
        #1;
        check("R8 lower step", int'(dec_step), 2);
        check("R5 R6 lower adjusted", int'(dec_word), al);
        check("R8 lower parity", int'(dec_par), chk);
        dec_mask = lm[N-1:0];

        @(negedge clk);
        dec_done = 1'b0;
        #1;
        check("R10 done pulse", int'(done), 1);
        check("R7 corrected upper", int'(msb_out), am ^ mm);
        check("R8 corrected lower", int'(lsb_out), al ^ lm);

        @(negedge clk);
        #1;
        check("R10 done low", {int'(done), int'(busy)}, 0);
        check("R10 pages held", {int'(msb_out), int'(lsb_out)}, {am ^ mm, al ^ lm});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset state", {int'(busy), int'(done), int'(dec_req)}, 0);
        check("R1 reset pages", {int'(msb_out), int'(lsb_out)}, 0);
        rst_n = 1'b1;
        for (int m = 0; m < 16; m++)
            for (int l = 0; l < 16; l++)
                for (int e = 0; e < 16; e++)
                    run_one(m, l, e, (m + l + e) % 3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule